// File: doc/BRIEF.md
# USB Control SETUP Capture Unit

This unit sits between the token/packet decoder of a USB device and its CPU. When a SETUP token arrives, it records the target endpoint and empties whatever the previous request left behind. It tells the endpoint logic to drop the stall condition on that endpoint. It then collects the request bytes and the CRC16 trailer into a short queue. At the end of a packet with a good CRC, it always asks the packet layer to send an ACK and raises a ready event. A SETUP packet is never refused.

Software reads the request one byte at a time from a data register, and each read moves the queue forward. It can also flush the queue and read a status byte that summarises the last request. Two events, request ready and USB bus reset, each have a raw level, a write-1-to-clear pending bit and an enable bit, and together they form an interrupt. The unit also holds the 7-bit device address, which a bus reset clears. It merges its own pending events with the pending flags of the IN and OUT handlers into a one-hot indicator that tells software which event to serve first.

The CPU port is a simple 3-bit-address register port. Read data is combinational from the address, and a read strobe on the data register pops one byte.

Top module: `usb_setup_capture`

## Requirements
- R1: One cycle after `rx_end_i` with `rx_crc_ok_i` high closes a SETUP packet, `ack_o` pulses for one cycle. This happens whatever the queue holds. A packet closed with a bad CRC gives no ACK.
- R2: A SETUP token (`tok_setup_i`) empties the queue and clears the IS_IN and DATA status flags before any byte of the new packet is stored.
- R3: The queue keeps the first 10 bytes of the packet (8 request bytes, then 2 CRC bytes). Any further bytes are dropped. A read at address 0 returns the oldest byte and advances the queue. A read at address 0 with the queue empty returns 0.
- R4: One cycle after a SETUP token, `stall_clr_o` pulses for one cycle and `stall_clr_ep_o` carries the token's endpoint.
- R5: The status byte at address 2 holds the token endpoint in bits 3:0. Bit 4 is set when the queue is not empty. Bit 5 is the ready pending bit. Bit 6 copies bit 7 of request byte 0. Bit 7 is set when request byte 6 or byte 7 is nonzero.
- R6: Writing to address 1 with bit 5 set empties the queue.
- R7: Events use bit 0 for ready and bit 1 for bus reset. Address 3 gives the raw levels: the queue is not empty, and `bus_reset_i`. Address 4 holds the pending bits. Ready is set by a good packet end and bus reset by a rising edge of `bus_reset_i`. Writing 1 to a bit at address 4 clears it, and a new set in the same cycle wins over the clear. Address 5 holds the enables. `irq_o` is the OR of pending AND enable.
- R8: `next_ev_o` and address 6 show bit 3 for bus reset, bit 2 for SETUP ready, bit 1 for OUT (`out_pend_i`) and bit 0 for IN (`in_pend_i`). Only the highest pending bit is shown, with priority in that order from bit 3 down, so the value is always one-hot or zero.
- R9: Address 7 holds the device address, which a CPU write sets from bits 6:0. Any cycle with `bus_reset_i` high sets it to zero, overriding a write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_setup_i | input | 1 | SETUP token received (one-cycle pulse) |
| tok_epno_i | input | 4 | Endpoint of the SETUP token |
| rx_valid_i | input | 1 | Packet data byte valid |
| rx_byte_i | input | 8 | Packet data byte |
| rx_end_i | input | 1 | Packet end |
| rx_crc_ok_i | input | 1 | CRC good, qualified by rx_end_i |
| ack_o | output | 1 | Request an ACK handshake |
| stall_clr_o | output | 1 | Clear stall on the endpoint given |
| stall_clr_ep_o | output | 4 | Endpoint whose stall is cleared |
| bus_reset_i | input | 1 | USB bus reset level |
| in_pend_i | input | 1 | IN handler event pending |
| out_pend_i | input | 1 | OUT handler event pending |
| cpu_addr_i | input | 3 | Register address |
| cpu_wr_i | input | 1 | Register write strobe |
| cpu_rd_i | input | 1 | Register read strobe |
| cpu_wdata_i | input | 8 | Register write data |
| cpu_rdata_o | output | 8 | Register read data |
| next_ev_o | output | 4 | One-hot next event to serve |
| irq_o | output | 1 | Interrupt request |
| dev_addr_o | output | 7 | Device address |

## Verification
The bench sends a second SETUP while the first is only partly read. A design that appends instead of flushing would hand software stale bytes and a stale IS_IN flag. An over-long packet checks the 10-byte cap, since a wrapping queue would overwrite the request with the CRC. Reads past empty must return 0. Bus reset is pulsed while a CPU address write happens in the same cycle, and a pending clear is timed against a new ready event, so that wrong priority on either shows up. IN and OUT pending flags are combined with the unit's own events to show whether the next-event output ever reports a lower event or more than one bit.

// File: rtl/usb_setup_pkg.sv
package usb_setup_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned EP_W     = 4;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned DEVA_W   = 7;
  localparam int unsigned REQ_LEN  = 8;
  localparam int unsigned CRC_LEN  = 2;
  localparam int unsigned Q_DEPTH  = REQ_LEN + CRC_LEN;
  localparam int unsigned N_EV     = 2;
  localparam int unsigned N_SRC    = 4;

  localparam logic [ADDR_W-1:0] RA_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] RA_CTRL  = 3'd1;
  localparam logic [ADDR_W-1:0] RA_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] RA_RAW   = 3'd3;
  localparam logic [ADDR_W-1:0] RA_PEND  = 3'd4;
  localparam logic [ADDR_W-1:0] RA_ENA   = 3'd5;
  localparam logic [ADDR_W-1:0] RA_NEXT  = 3'd6;
  localparam logic [ADDR_W-1:0] RA_DEVA  = 3'd7;

  localparam int unsigned CTRL_FLUSH_BIT = 5;
  localparam int unsigned EV_READY = 0;
  localparam int unsigned EV_BRST  = 1;
endpackage

// File: rtl/setup_byte_queue.sv
module setup_byte_queue #(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned W     = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && (cnt_q < CW'(DEPTH)) && !flush;
  assign do_pop  = pop && (cnt_q != '0) && !flush;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = wrap_inc(wp_q);
      if (do_pop)  rp_d = wrap_inc(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= din;
  end

  assign head  = (cnt_q == '0) ? '0 : mem_q[rp_q];
  assign count = cnt_q;
endmodule

// File: rtl/setup_event_bank.sv
module setup_event_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr,
  input  logic         ena_wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] pending,
  output logic [N-1:0] enable,
  output logic         irq
);
  logic [N-1:0] pend_d, pend_q, ena_d, ena_q;

  for (genvar i = 0; i < N; i++) begin : g_ev
    always_comb begin
      pend_d[i] = pend_q[i];
      if (clr_wr && wdata[i]) pend_d[i] = 1'b0;
      if (set_i[i])           pend_d[i] = 1'b1;
      ena_d[i] = ena_wr ? wdata[i] : ena_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ena_q  <= '0;
    end else begin
      pend_q <= pend_d;
      ena_q  <= ena_d;
    end
  end

  assign pending = pend_q;
  assign enable  = ena_q;
  assign irq     = |(pend_q & ena_q);
endmodule

// File: rtl/next_event_pick.sv
module next_event_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick
);
  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/usb_setup_capture.sv
module usb_setup_capture
  import usb_setup_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tok_setup_i,
  input  logic [3:0]  tok_epno_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_byte_i,
  input  logic        rx_end_i,
  input  logic        rx_crc_ok_i,
  output logic        ack_o,
  output logic        stall_clr_o,
  output logic [3:0]  stall_clr_ep_o,
  input  logic        bus_reset_i,
  input  logic        in_pend_i,
  input  logic        out_pend_i,
  input  logic [2:0]  cpu_addr_i,
  input  logic        cpu_wr_i,
  input  logic        cpu_rd_i,
  input  logic [7:0]  cpu_wdata_i,
  output logic [7:0]  cpu_rdata_o,
  output logic [3:0]  next_ev_o,
  output logic        irq_o,
  output logic [6:0]  dev_addr_o
);
  localparam int unsigned CW    = $clog2(Q_DEPTH + 1);
  localparam int unsigned IDX_W = $clog2(Q_DEPTH + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // front end state
  logic              in_pkt_q, in_pkt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [EP_W-1:0]   ep_q, ep_d;
  logic              is_in_q, is_in_d;
  logic              wlnz_q, wlnz_d;
  logic              ack_q, ack_d;
  logic              stc_q, stc_d;
  logic              brst_q;
  logic [DEVA_W-1:0] deva_q, deva_d;

  logic              q_flush, q_push, q_pop, pkt_good, byte_take;
  logic [BYTE_W-1:0] q_head;
  logic [CW-1:0]     fifo_cnt;
  logic [N_EV-1:0]   ev_set, ev_pend, ev_ena;
  logic              wr_ctrl, wr_pend, wr_ena, wr_deva;

  assign wr_ctrl = cpu_wr_i && (cpu_addr_i == RA_CTRL);
  assign wr_pend = cpu_wr_i && (cpu_addr_i == RA_PEND);
  assign wr_ena  = cpu_wr_i && (cpu_addr_i == RA_ENA);
  assign wr_deva = cpu_wr_i && (cpu_addr_i == RA_DEVA);

  assign byte_take = rx_valid_i && in_pkt_q && !tok_setup_i;
  assign pkt_good  = rx_end_i && rx_crc_ok_i && in_pkt_q && !tok_setup_i;
  assign q_flush   = tok_setup_i || (wr_ctrl && cpu_wdata_i[CTRL_FLUSH_BIT]);
  assign q_push    = byte_take;
  assign q_pop     = cpu_rd_i && (cpu_addr_i == RA_DATA);

  always_comb begin
    in_pkt_d = in_pkt_q;
    idx_d    = idx_q;
    ep_d     = ep_q;
    is_in_d  = is_in_q;
    wlnz_d   = wlnz_q;
    ack_d    = pkt_good;
    stc_d    = tok_setup_i;
    deva_d   = deva_q;
    if (tok_setup_i) begin
      in_pkt_d = 1'b1;
      idx_d    = '0;
      ep_d     = tok_epno_i;
      is_in_d  = 1'b0;
      wlnz_d   = 1'b0;
    end else begin
      if (byte_take) begin
        if (idx_q == '0) is_in_d = rx_byte_i[7];
        if ((idx_q == IDX_W'(6) || idx_q == IDX_W'(7)) && rx_byte_i != '0)
          wlnz_d = 1'b1;
        if (idx_q != '1) idx_d = idx_q + 1'b1;
      end
      if (rx_end_i) in_pkt_d = 1'b0;
    end
    if (wr_deva)     deva_d = cpu_wdata_i[DEVA_W-1:0];
    if (bus_reset_i) deva_d = '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      in_pkt_q <= 1'b0;
      idx_q    <= '0;
      ep_q     <= '0;
      is_in_q  <= 1'b0;
      wlnz_q   <= 1'b0;
      ack_q    <= 1'b0;
      stc_q    <= 1'b0;
      brst_q   <= 1'b0;
      deva_q   <= '0;
    end else begin
      in_pkt_q <= in_pkt_d;
      idx_q    <= idx_d;
      ep_q     <= ep_d;
      is_in_q  <= is_in_d;
      wlnz_q   <= wlnz_d;
      ack_q    <= ack_d;
      stc_q    <= stc_d;
      brst_q   <= bus_reset_i;
      deva_q   <= deva_d;
    end
  end

  setup_byte_queue #(.DEPTH(Q_DEPTH), .W(BYTE_W)) u_queue (
    .clk   (clk),
    .rst_n (rst_int_n),
    .flush (q_flush),
    .push  (q_push),
    .din   (rx_byte_i),
    .pop   (q_pop),
    .head  (q_head),
    .count (fifo_cnt)
  );

  assign ev_set[EV_READY] = pkt_good;
  assign ev_set[EV_BRST]  = bus_reset_i && !brst_q;

  setup_event_bank #(.N(N_EV)) u_events (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_i   (ev_set),
    .clr_wr  (wr_pend),
    .ena_wr  (wr_ena),
    .wdata   (cpu_wdata_i[N_EV-1:0]),
    .pending (ev_pend),
    .enable  (ev_ena),
    .irq     (irq_o)
  );

  next_event_pick #(.N(N_SRC)) u_pick (
    .req  ({ev_pend[EV_BRST], ev_pend[EV_READY], out_pend_i, in_pend_i}),
    .pick (next_ev_o)
  );

  logic q_have;
  assign q_have = (fifo_cnt != '0);

  always_comb begin
    unique case (cpu_addr_i)
      RA_DATA: cpu_rdata_o = q_head;
      RA_CTRL: cpu_rdata_o = '0;
      RA_STAT: cpu_rdata_o = {wlnz_q, is_in_q, ev_pend[EV_READY], q_have, ep_q};
      RA_RAW:  cpu_rdata_o = {6'b0, bus_reset_i, q_have};
      RA_PEND: cpu_rdata_o = {6'b0, ev_pend};
      RA_ENA:  cpu_rdata_o = {6'b0, ev_ena};
      RA_NEXT: cpu_rdata_o = {4'b0, next_ev_o};
      default: cpu_rdata_o = {1'b0, deva_q};
    endcase
  end

  assign ack_o          = ack_q;
  assign stall_clr_o    = stc_q;
  assign stall_clr_ep_o = ep_q;
  assign dev_addr_o     = deva_q;
endmodule

// File: rtl/usb_setup_capture_chk.sv
module usb_setup_capture_chk #(
  parameter int unsigned DEPTH = 10,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tok_setup_i,
  input logic          rx_end_i,
  input logic          rx_crc_ok_i,
  input logic          bus_reset_i,
  input logic          ack_o,
  input logic          stall_clr_o,
  input logic [3:0]    next_ev_o,
  input logic [6:0]    dev_addr_o,
  input logic [CW-1:0] fifo_cnt
);
  a_r1_ack_after_good_end: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(rx_end_i && rx_crc_ok_i));
  a_r2_token_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    tok_setup_i |=> (fifo_cnt == '0));
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));
  a_r4_stall_clear_follows_token: assert property (@(posedge clk) disable iff (!rst_n)
    stall_clr_o |-> $past(tok_setup_i));
  a_r8_next_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(next_ev_o));
  a_r9_bus_reset_clears_addr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_i |=> (dev_addr_o == '0));
endmodule

bind usb_setup_capture usb_setup_capture_chk #(.DEPTH(usb_setup_pkg::Q_DEPTH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tok_setup_i (tok_setup_i),
  .rx_end_i    (rx_end_i),
  .rx_crc_ok_i (rx_crc_ok_i),
  .bus_reset_i (bus_reset_i),
  .ack_o       (ack_o),
  .stall_clr_o (stall_clr_o),
  .next_ev_o   (next_ev_o),
  .dev_addr_o  (dev_addr_o),
  .fifo_cnt    (fifo_cnt)
);

// File: tb/usb_setup_capture_tb_top.sv
module usb_setup_capture_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tok_setup_i = 1'b0;
  logic [3:0] tok_epno_i = '0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_byte_i = '0;
  logic       rx_end_i = 1'b0;
  logic       rx_crc_ok_i = 1'b0;
  logic       bus_reset_i = 1'b0;
  logic       in_pend_i = 1'b0;
  logic       out_pend_i = 1'b0;
  logic [2:0] cpu_addr_i = '0;
  logic       cpu_wr_i = 1'b0;
  logic       cpu_rd_i = 1'b0;
  logic [7:0] cpu_wdata_i = '0;
  logic       ack_o, stall_clr_o, irq_o;
  logic [3:0] stall_clr_ep_o, next_ev_o;
  logic [7:0] cpu_rdata_o;
  logic [6:0] dev_addr_o;

  always #10 clk = ~clk;

  usb_setup_capture dut_i (.*);

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // ---------------- behavioural reference ----------------
  logic [7:0] mq[$];
  logic [3:0] m_ep = '0;
  logic       m_in_pkt = 0, m_is_in = 0, m_wlnz = 0, m_ack = 0, m_stc = 0;
  logic       m_rdy = 0, m_brp = 0, m_prev_br = 0;
  logic [1:0] m_ena = '0;
  logic [6:0] m_addr = '0;
  int         m_idx = 0;

  function automatic logic [3:0] m_next();
    if (m_brp)      return 4'b1000;
    if (m_rdy)      return 4'b0100;
    if (out_pend_i) return 4'b0010;
    if (in_pend_i)  return 4'b0001;
    return 4'b0000;
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return (mq.size() != 0) ? mq[0] : 8'h00;
      3'd1: return 8'h00;
      3'd2: return {m_wlnz, m_is_in, m_rdy, mq.size() != 0, m_ep};
      3'd3: return {6'b0, bus_reset_i, mq.size() != 0};
      3'd4: return {6'b0, m_brp, m_rdy};
      3'd5: return {6'b0, m_ena};
      3'd6: return {4'b0, m_next()};
      default: return {1'b0, m_addr};
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_ep = '0; m_in_pkt = 0; m_is_in = 0; m_wlnz = 0;
      m_ack = 0; m_stc = 0; m_rdy = 0; m_brp = 0; m_prev_br = 0;
      m_ena = '0; m_addr = '0; m_idx = 0;
    end else begin
      logic good, full0, flush;
      good  = m_in_pkt && rx_end_i && rx_crc_ok_i && !tok_setup_i;
      full0 = (mq.size() >= 10);
      flush = tok_setup_i || (cpu_wr_i && cpu_addr_i == 3'd1 && cpu_wdata_i[5]);
      m_ack = good;
      m_stc = tok_setup_i;
      if (cpu_rd_i && cpu_addr_i == 3'd0 && mq.size() != 0 && !flush) void'(mq.pop_front());
      if (tok_setup_i) begin
        m_in_pkt = 1; m_ep = tok_epno_i; m_idx = 0; m_is_in = 0; m_wlnz = 0;
      end else begin
        if (rx_valid_i && m_in_pkt) begin
          if (!full0 && !flush) mq.push_back(rx_byte_i);
          if (m_idx == 0) m_is_in = rx_byte_i[7];
          if ((m_idx == 6 || m_idx == 7) && rx_byte_i != 0) m_wlnz = 1;
          m_idx++;
        end
        if (rx_end_i) m_in_pkt = 0;
      end
      if (flush) mq.delete();
      if (cpu_wr_i && cpu_addr_i == 3'd4) begin
        if (cpu_wdata_i[0]) m_rdy = 0;
        if (cpu_wdata_i[1]) m_brp = 0;
      end
      if (good) m_rdy = 1;
      if (bus_reset_i && !m_prev_br) m_brp = 1;
      m_prev_br = bus_reset_i;
      if (cpu_wr_i && cpu_addr_i == 3'd5) m_ena = cpu_wdata_i[1:0];
      if (cpu_wr_i && cpu_addr_i == 3'd7) m_addr = cpu_wdata_i[6:0];
      if (bus_reset_i) m_addr = '0;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare outputs on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 ack", {7'b0, ack_o}, {7'b0, m_ack});
      chk("R4 stall_clr", {7'b0, stall_clr_o}, {7'b0, m_stc});
      if (m_stc) chk("R4 stall_clr_ep", {4'b0, stall_clr_ep_o}, {4'b0, m_ep});
      chk("R8 next_ev", {4'b0, next_ev_o}, {4'b0, m_next()});
      chk("R7 irq", {7'b0, irq_o}, {7'b0, |({m_brp, m_rdy} & m_ena)});
      chk("R9 dev_addr", {1'b0, dev_addr_o}, {1'b0, m_addr});
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [7:0] pkt[$];

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_setup(input logic [3:0] ep, input logic crc_ok);
    @(negedge clk); tok_setup_i = 1; tok_epno_i = ep;
    @(negedge clk); tok_setup_i = 0;
    foreach (pkt[i]) begin
      rx_valid_i = 1; rx_byte_i = pkt[i];
      @(negedge clk);
    end
    rx_valid_i = 0; rx_end_i = 1; rx_crc_ok_i = crc_ok;
    @(negedge clk); rx_end_i = 0; rx_crc_ok_i = 0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    cpu_addr_i = a; cpu_rd_i = 1;
    #1 chk(tag, cpu_rdata_o, m_read(a));
    @(negedge clk); cpu_rd_i = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cpu_addr_i = a; cpu_wdata_i = d; cpu_wr_i = 1;
    @(negedge clk); cpu_wr_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(4);
    // reset state
    for (int a = 0; a < 8; a++) rd(3'(a), "R5 R7 R9 reset value");

    // request to EP0, device-to-host, wLength 0x40
    pkt = '{8'h80, 8'h06, 8'h00, 8'h01, 8'h00, 8'h00, 8'h40, 8'h00, 8'hAA, 8'h55};
    send_setup(4'd0, 1'b1);
    rd(3'd2, "R5 status after packet");
    rd(3'd3, "R7 raw ready level");
    rd(3'd4, "R1 R7 ready pending");
    rd(3'd0, "R3 byte0"); rd(3'd0, "R3 byte1"); rd(3'd0, "R3 byte2");

    // second request while undrained: host-to-device, wLength 0, EP5
    pkt = '{8'h00, 8'h09, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h12, 8'h34};
    send_setup(4'd5, 1'b1);
    rd(3'd2, "R2 R5 status after overwrite");
    for (int i = 0; i < 11; i++) rd(3'd0, "R2 R3 drain and empty read");
    rd(3'd2, "R5 status empty");

    // over-long packet keeps first 10 bytes; wLength high byte nonzero
    pkt = '{8'h81, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h00, 8'h01,
            8'h08, 8'h09, 8'hEE, 8'hEF};
    send_setup(4'd2, 1'b1);
    rd(3'd2, "R5 status long packet");
    for (int i = 0; i < 11; i++) rd(3'd0, "R3 cap at ten bytes");

    // software flush
    pkt = '{8'h21, 8'h0A, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02};
    send_setup(4'd1, 1'b1);
    wr(3'd1, 8'h20);
    rd(3'd2, "R6 flush clears have");
    rd(3'd0, "R6 data after flush");

    // bad CRC: no ack, no new ready
    wr(3'd4, 8'h01);
    rd(3'd4, "R7 pending cleared");
    send_setup(4'd3, 1'b0);
    rd(3'd4, "R1 no ready on bad crc");

    // events, enables, irq, next-event priority
    in_pend_i = 1; idle(1); rd(3'd6, "R8 in only");
    out_pend_i = 1; idle(1); rd(3'd6, "R8 out over in");
    wr(3'd5, 8'h03); rd(3'd5, "R7 enable readback");
    pkt = '{8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h00, 8'h00, 8'h00};
    send_setup(4'd0, 1'b1);
    rd(3'd6, "R8 setup over out");
    wr(3'd7, 8'h2A); rd(3'd7, "R9 address written");
    // bus reset coinciding with address write
    cpu_addr_i = 3'd7; cpu_wdata_i = 8'h11; cpu_wr_i = 1; bus_reset_i = 1;
    @(negedge clk); cpu_wr_i = 0;
    rd(3'd3, "R7 raw reset level");
    bus_reset_i = 0;
    rd(3'd7, "R9 address cleared by reset");
    rd(3'd6, "R8 reset highest");
    rd(3'd4, "R7 both pending");
    wr(3'd4, 8'h02); rd(3'd6, "R8 setup after reset cleared");
    // clear ready in the same cycle a new packet completes: set wins
    pkt = '{8'h00, 8'h05, 8'h07, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    @(negedge clk); tok_setup_i = 1; tok_epno_i = 4'd0;
    @(negedge clk); tok_setup_i = 0;
    foreach (pkt[i]) begin rx_valid_i = 1; rx_byte_i = pkt[i]; @(negedge clk); end
    rx_valid_i = 0; rx_end_i = 1; rx_crc_ok_i = 1;
    cpu_addr_i = 3'd4; cpu_wdata_i = 8'h01; cpu_wr_i = 1;
    @(negedge clk); rx_end_i = 0; rx_crc_ok_i = 0; cpu_wr_i = 0;
    rd(3'd4, "R7 set wins over clear");
    wr(3'd5, 8'h00); rd(3'd5, "R7 enables off");
    in_pend_i = 0; out_pend_i = 0;
    wr(3'd4, 8'h03); rd(3'd6, "R8 nothing pending");
    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule